// File: doc/BRIEF.md
# Second-Order Sigma-Delta Pulse-Density Modulator

This block turns a parallel two's-complement sample into a one-bit pulse stream on a single output pin. An external RC low-pass filter on that pin recovers the analog waveform. Inside are a register that captures the sample, two cascaded integrators, and a one-bit quantizer. The quantizer's decision is fed back as the positive or negative full-scale level. The sample width is a parameter, and the default is 24 bits.

The block has two output modes. In plain mode the loop advances on every clock and the pin carries the decision register directly, which gives the highest oversampling ratio. In symmetric mode the loop advances once every three clocks. Each decision is emitted as a return-to-zero group: `1,1,0` for a one and `1,0,0` for a zero. Every group therefore holds exactly one rising edge and one falling edge, whatever the signal value is, so unequal rise and fall times of the pin driver cannot cause distortion that depends on the signal. The mode input is meant to be held steady between resets.

Top module: `sdm2_dac`

## Requirements
- R1: While `rst` is high at a clock edge, `pulse_out` is 0 after that edge. Both integrators, the decision bit and the group phase are cleared.
- R2: In plain mode (`sym_mode`=0) with a constant positive input x, the count of ones over N consecutive clocks equals N·(x+2^(W-1))/2^W within ±12. W is the sample width, 24 by default.
- R3: The input is read as two's-complement signed. In plain mode a constant negative input gives the same ones density law as R2, which is below one half.
- R4: In symmetric mode (`sym_mode`=1), each group of three clocks, counted from the first clock edge after reset is released, is `1,b,0`. Here b is the decision for that group, and b stays fixed for the whole group.
- R5: In symmetric mode with a constant input x, the count of groups with b=1 over G groups equals G·(x+2^(W-1))/2^W within ±12.
- R6: For constant inputs with |x| ≤ 2^(W-2), both integrators stay in range without wrapping. The ones density therefore still follows the R2 law at the extremes of that range.
- R7: In symmetric mode, a run of G groups contains exactly G rising edges and G falling edges on `pulse_out`.
- R8: In plain mode the group phase counter stays at its first phase, so the loop advances on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_mode | input | 1 | 0: plain mode, one decision per clock; 1: symmetric three-clock groups |
| sample_in | input | IN_W | Two's-complement input sample |
| pulse_out | output | 1 | Registered one-bit pulse stream |

## Verification
The pin is registered, so the value produced by the pattern logic at edge k is read at the falling edge that follows edge k. In symmetric mode the first group starts at the first rising edge after reset is released. Reset is released on a falling edge, so the bench reads three consecutive falling edges as one group, and the group boundaries are known without looking inside the design. The input register adds one loop cycle of delay, and the loop takes a short time to settle from reset. Both effects add only a few counts to the ones totals, so the density checks allow a fixed margin of ±12 over runs of 2048 clocks or 1024 groups.

// File: rtl/sdm2_pkg.sv
package sdm2_pkg;

    typedef enum logic {
        MODE_PLAIN = 1'b0,
        MODE_SYM   = 1'b1
    } out_mode_e;

    typedef enum logic [1:0] {
        PH_LEAD = 2'd0,
        PH_DATA = 2'd1,
        PH_TAIL = 2'd2
    } grp_phase_e;

    // Next phase of a three-clock group; plain mode parks on the lead phase.
    function automatic grp_phase_e next_phase(input out_mode_e mode, input grp_phase_e ph);
        if (mode == MODE_PLAIN) return PH_LEAD;
        case (ph)
            PH_LEAD: return PH_DATA;
            PH_DATA: return PH_TAIL;
            default: return PH_LEAD;
        endcase
    endfunction

    // Pin level for a phase of a return-to-zero group.
    function automatic logic rz_level(input grp_phase_e ph, input logic decision);
        case (ph)
            PH_LEAD: return 1'b1;
            PH_DATA: return decision;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sdm2_phase_ctrl.sv
module sdm2_phase_ctrl
    import sdm2_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  out_mode_e  mode,
    output grp_phase_e phase,
    output logic       advance
);

    grp_phase_e ph_q;

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_LEAD;
        else     ph_q <= next_phase(mode, ph_q);
    end

    assign phase   = ph_q;
    assign advance = (mode == MODE_PLAIN) || (ph_q == PH_TAIL);

    // R8: plain mode keeps the counter on its first phase
    p_phase_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PLAIN) |=> (ph_q == PH_LEAD));

    // R4: the phase never leaves its three legal codes
    p_phase_range_r4: assert property (@(posedge clk) disable iff (rst)
        (ph_q != 2'd3));

endmodule

// File: rtl/sdm2_loop.sv
module sdm2_loop #(
    parameter int IN_W  = 24,
    parameter int GUARD = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            advance,
    input  logic [IN_W-1:0] sample_in,
    output logic            decision
);

    localparam int ACC_W = IN_W + GUARD;
    localparam logic signed [ACC_W-1:0] FS_POS = ACC_W'(1) <<< (IN_W - 1);
    localparam logic signed [ACC_W-1:0] FS_NEG = -FS_POS;

    logic [IN_W-1:0]         xr_q;
    logic signed [ACC_W-1:0] x_ext, fb, int1_q, int2_q, int1_d, int2_d;
    logic                    dec_q;

    always_comb begin
        x_ext  = {{GUARD{xr_q[IN_W-1]}}, xr_q};
        fb     = dec_q ? FS_POS : FS_NEG;
        int1_d = int1_q + x_ext - fb;
        int2_d = int2_q + int1_d - fb;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xr_q   <= '0;
            int1_q <= '0;
            int2_q <= '0;
            dec_q  <= 1'b0;
        end else if (advance) begin
            xr_q   <= sample_in;
            int1_q <= int1_d;
            int2_q <= int2_d;
            dec_q  <= ~int2_d[ACC_W-1];
        end
    end

    assign decision = dec_q;

    // R6: no integrator approaches its wrap point
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (int1_q[ACC_W-1] == int1_q[ACC_W-2]) && (int2_q[ACC_W-1] == int2_q[ACC_W-2]));

    // R4: the decision is held between loop advances
    p_decision_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(dec_q));

endmodule

// File: rtl/sdm2_shaper.sv
module sdm2_shaper
    import sdm2_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  out_mode_e  mode,
    input  grp_phase_e phase,
    input  logic       decision,
    output logic       pin
);

    logic pin_q;

    always_ff @(posedge clk) begin
        if (rst)                     pin_q <= 1'b0;
        else if (mode == MODE_PLAIN) pin_q <= decision;
        else                         pin_q <= rz_level(phase, decision);
    end

    assign pin = pin_q;

    // R1: reset drives the pin low on the next edge
    p_out_low_r1: assert property (@(posedge clk) rst |=> !pin_q);

    // R4: a tail phase in symmetric mode is always followed by a low pin
    p_tail_low_r4: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SYM) && (phase == PH_TAIL) |=> !pin_q);

endmodule

// File: rtl/sdm2_dac.sv
module sdm2_dac
    import sdm2_pkg::*;
#(
    parameter int IN_W  = 24,
    parameter int GUARD = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sym_mode,
    input  logic [IN_W-1:0] sample_in,
    output logic            pulse_out
);

    out_mode_e  mode;
    grp_phase_e phase;
    logic       advance;
    logic       decision;

    assign mode = sym_mode ? MODE_SYM : MODE_PLAIN;

    sdm2_phase_ctrl u_phase (
        .clk     (clk),
        .rst     (rst),
        .mode    (mode),
        .phase   (phase),
        .advance (advance)
    );

    sdm2_loop #(.IN_W(IN_W), .GUARD(GUARD)) u_loop (
        .clk       (clk),
        .rst       (rst),
        .advance   (advance),
        .sample_in (sample_in),
        .decision  (decision)
    );

    sdm2_shaper u_shape (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .phase    (phase),
        .decision (decision),
        .pin      (pulse_out)
    );

endmodule

// File: tb/sdm2_dac_tb.sv
module sdm2_dac_tb_top;

    localparam int  CLK_PERIOD = 10;
    localparam int  IN_W       = 24;
    localparam int  FS         = 2 ** (IN_W - 1);
    localparam int  N_PLAIN    = 2048;
    localparam int  N_GRP      = 1024;
    localparam real TOL        = 12.0;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            sym_mode = 1'b0;
    logic [IN_W-1:0] sample_in = '0;
    logic            pulse_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    sdm2_dac #(.IN_W(IN_W)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .sym_mode  (sym_mode),
        .sample_in (sample_in),
        .pulse_out (pulse_out)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected below 200000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_ones(input int x, input int n);
        return int'(real'(n) * (real'(x) + real'(FS)) / (2.0 * real'(FS)));
    endfunction

    // Reset in the given mode; release on a falling edge.
    task automatic do_reset(input bit sym, input int x);
        @(negedge clk);
        rst       = 1'b1;
        sym_mode  = sym;
        sample_in = IN_W'(x);
        repeat (3) @(negedge clk);
        chk(pulse_out == 1'b0, "R1 pin low in reset", int'(pulse_out), 0);
        rst = 1'b0;
    endtask

    task automatic t_plain(input int x, input string req);
        int ones = 0;
        int exp;
        do_reset(1'b0, x);
        for (int i = 0; i < N_PLAIN; i++) begin
            @(negedge clk);
            ones += int'(pulse_out);
        end
        exp = expect_ones(x, N_PLAIN);
        chk((real'(ones) - real'(exp)) <= TOL && (real'(exp) - real'(ones)) <= TOL,
            req, ones, exp);
    endtask

    task automatic t_sym(input int x);
        int   mids = 0, rises = 0, falls = 0, badgrp = 0, exp;
        logic prev = 1'b0;
        logic g [3];
        do_reset(1'b1, x);
        for (int gi = 0; gi < N_GRP; gi++) begin
            for (int p = 0; p < 3; p++) begin
                @(negedge clk);
                g[p] = pulse_out;
                if (!prev && pulse_out) rises++;
                if (prev && !pulse_out) falls++;
                prev = pulse_out;
            end
            if (!(g[0] == 1'b1 && g[2] == 1'b0)) badgrp++;
            mids += int'(g[1]);
        end
        chk(badgrp == 0, "R4 every group is 1,b,0", badgrp, 0);
        exp = expect_ones(x, N_GRP);
        chk((real'(mids) - real'(exp)) <= TOL && (real'(exp) - real'(mids)) <= TOL,
            "R5 symmetric density", mids, exp);
        chk(rises == N_GRP, "R7 rising edges per run", rises, N_GRP);
        chk(falls == N_GRP, "R7 falling edges per run", falls, N_GRP);
    endtask

    initial begin
        t_plain(FS / 4,       "R2 plain density +FS/4");
        t_plain(3 * FS / 16,  "R2 plain density +3FS/16");
        t_plain(0,            "R2 plain density zero");
        t_plain(-FS / 4,      "R3 plain density -FS/4");
        t_plain(-FS / 8,      "R3 plain density -FS/8");
        t_plain(FS / 2,       "R6 plain density +FS/2");
        t_plain(-FS / 2,      "R6 plain density -FS/2");
        t_sym(FS / 4);
        t_sym(-3 * FS / 8);
        t_plain(FS / 8,       "R8 plain after symmetric run");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule